// File: doc/BRIEF.md
# Interrupt Controller Local Countdown Timer

This block is the local timer of an interrupt controller. Software programs a 32-bit timer entry word that holds an interrupt vector, a delivery mode, a trigger mode, a mask bit and a periodic bit. It then writes a starting count. The count runs down by one on every clock. When it expires, the block looks at the entry word. If the entry is unmasked, the block emits a one-cycle interrupt request that carries the vector, the delivery mode and a level/edge flag.

In periodic mode the counter reloads from the stored starting count and keeps running. This happens on every expiry, including a masked one, so the period never drifts. In one-shot mode the counter stops at zero.

A small word-addressed write/read port gives access to the entry word, the starting count and the live count. Passing the request on to a processor is left to the surrounding controller.

Top module: `irq_count_timer`

## Requirements
- R1: After reset, every register address reads zero and `req_valid` is low.
- R2: The entry word at address 0 keeps these fields: vector in bits 7:0, delivery mode in bits 10:8, polarity in bit 13, trigger mode in bit 15 (1 = level), mask in bit 16 and periodic in bit 17. Bit 12 (status), bit 14 (remote request) and the reserved bits 11 and 31:18 always read zero, so writing all ones reads back 0x0003A7FF.
- R3: Writing a nonzero value N to address 1 (starting count) loads the live count, which is read at address 2. The live count reads N in the cycle after the write and then falls by one per clock.
- R4: N clocks after the write of N, the timer expires. If the mask bit is clear, `req_valid` is high for exactly that cycle. In that cycle `req_vector`, `req_mode` and `req_level` equal entry bits 7:0, bits 10:8 and bit 15.
- R5: An expiry while the mask bit (bit 16) is set raises no request.
- R6: With the periodic bit (bit 17) set, each expiry reloads the live count with the starting count. Expiries therefore repeat every N clocks, and the reload happens whether the entry is masked or not.
- R7: With the periodic bit clear, the live count reads zero after the single expiry and stays there, and no further request follows.
- R8: Writing zero to the starting count disarms the timer. The live count reads zero and no request is raised.
- R9: Writes to address 2 or address 3 have no effect, and address 3 reads zero.
- R10: Address 1 reads back the last value written to it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register word address (0 entry, 1 starting count, 2 live count) |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr` (combinational) |
| req_valid | output | 1 | One-cycle interrupt request |
| req_vector | output | 8 | Vector of the request |
| req_mode | output | 3 | Delivery mode of the request |
| req_level | output | 1 | 1 = level-triggered request, 0 = edge |

## Verification
The hardest case to reach from the ports is the boundary where expiry and reload coincide. The clearest example is a periodic count of one, which expires on every clock and must still read back as one. A masked periodic entry must keep its period even though it never shows a request. The stimulus covers this by sweeping every starting count from one to five against all eight combinations of mask, periodic and trigger bits. Each run lasts three periods, and the expected live count and request are computed cycle by cycle from the count value and the cycle index.

// File: rtl/irq_timer_pkg.sv
package irq_timer_pkg;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 2;

  localparam logic [ADDR_W-1:0] A_ENTRY = 2'd0;
  localparam logic [ADDR_W-1:0] A_START = 2'd1;
  localparam logic [ADDR_W-1:0] A_LIVE  = 2'd2;

  // Field positions of the timer entry word.
  localparam int VEC_LSB  = 0;
  localparam int VEC_W    = 8;
  localparam int MODE_LSB = 8;
  localparam int MODE_W   = 3;
  localparam int TRIG_BIT = 15;
  localparam int MASK_BIT = 16;
  localparam int PER_BIT  = 17;

  // Bits software can set: vector, mode, polarity, trigger, mask, periodic.
  localparam logic [DATA_W-1:0] ENTRY_WMASK = 32'h0003_A7FF;

  typedef struct packed {
    logic [VEC_W-1:0]  vector;
    logic [MODE_W-1:0] mode;
    logic              level;
  } irq_req_t;
endpackage

// File: rtl/irq_timer_regs.sv
module irq_timer_regs
  import irq_timer_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [CNT_W-1:0]  live_cnt,
  output logic [DATA_W-1:0] entry_q,
  output logic [CNT_W-1:0]  start_q,
  output logic              load_en,
  output logic [DATA_W-1:0] rdata
);
  logic              entry_en;
  logic [DATA_W-1:0] entry_d;
  logic [CNT_W-1:0]  start_d;

  always_comb begin
    entry_en = wr_en && (addr == A_ENTRY);
    load_en  = wr_en && (addr == A_START);
    entry_d  = wdata & ENTRY_WMASK;
    start_d  = wdata[CNT_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      entry_q <= '0;
    end else if (entry_en) begin
      entry_q <= entry_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_q <= '0;
    end else if (load_en) begin
      start_q <= start_d;
    end
  end

  always_comb begin
    case (addr)
      A_ENTRY: rdata = entry_q;
      A_START: rdata = DATA_W'(start_q);
      A_LIVE:  rdata = DATA_W'(live_cnt);
      default: rdata = '0;
    endcase
  end
endmodule

// File: rtl/irq_timer_counter.sv
module irq_timer_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_en,
  input  logic [CNT_W-1:0] load_val,
  input  logic [CNT_W-1:0] reload_val,
  input  logic             periodic,
  output logic [CNT_W-1:0] cnt_q,
  output logic             armed_q,
  output logic             expire
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic             cnt_en;
  logic [CNT_W-1:0] cnt_d;
  logic             armed_d;

  always_comb begin
    expire  = armed_q && (cnt_q == ONE) && !load_en;
    cnt_en  = load_en || armed_q;
    cnt_d   = cnt_q;
    armed_d = armed_q;
    if (load_en) begin
      cnt_d   = load_val;
      armed_d = (load_val != '0);
    end else if (cnt_q == ONE) begin
      if (periodic) begin
        cnt_d = reload_val;
      end else begin
        cnt_d   = '0;
        armed_d = 1'b0;
      end
    end else begin
      cnt_d = cnt_q - ONE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      armed_q <= 1'b0;
    end else if (cnt_en) begin
      cnt_q   <= cnt_d;
      armed_q <= armed_d;
    end
  end
endmodule

// File: rtl/irq_timer_issue.sv
module irq_timer_issue
  import irq_timer_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     expire,
  input  logic     masked,
  input  irq_req_t entry_req,
  output logic     req_valid,
  output irq_req_t req_q
);
  logic valid_d;

  always_comb begin
    valid_d = expire && !masked;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_valid <= 1'b0;
    end else begin
      req_valid <= valid_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q <= '0;
    end else if (valid_d) begin
      req_q <= entry_req;
    end
  end
endmodule

// File: rtl/irq_count_timer.sv
module irq_count_timer
  import irq_timer_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              req_valid,
  output logic [VEC_W-1:0]  req_vector,
  output logic [MODE_W-1:0] req_mode,
  output logic              req_level
);
  logic [DATA_W-1:0] entry_q;
  logic [CNT_W-1:0]  start_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              armed_q;
  logic              load_en;
  logic              expire;
  logic              ent_mask;
  logic              ent_per;
  irq_req_t          entry_req;
  irq_req_t          req_q;

  always_comb begin
    ent_mask         = entry_q[MASK_BIT];
    ent_per          = entry_q[PER_BIT];
    entry_req.vector = entry_q[VEC_LSB +: VEC_W];
    entry_req.mode   = entry_q[MODE_LSB +: MODE_W];
    entry_req.level  = entry_q[TRIG_BIT];
  end

  irq_timer_regs #(.CNT_W(CNT_W)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .addr     (addr),
    .wdata    (wdata),
    .live_cnt (cnt_q),
    .entry_q  (entry_q),
    .start_q  (start_q),
    .load_en  (load_en),
    .rdata    (rdata)
  );

  irq_timer_counter #(.CNT_W(CNT_W)) u_counter (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_en    (load_en),
    .load_val   (wdata[CNT_W-1:0]),
    .reload_val (start_q),
    .periodic   (ent_per),
    .cnt_q      (cnt_q),
    .armed_q    (armed_q),
    .expire     (expire)
  );

  irq_timer_issue u_issue (
    .clk       (clk),
    .rst_n     (rst_n),
    .expire    (expire),
    .masked    (ent_mask),
    .entry_req (entry_req),
    .req_valid (req_valid),
    .req_q     (req_q)
  );

  always_comb begin
    req_vector = req_q.vector;
    req_mode   = req_q.mode;
    req_level  = req_q.level;
  end
endmodule

// File: rtl/irq_count_timer_chk.sv
module irq_count_timer_chk #(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             load_en,
  input logic [CNT_W-1:0] start_q,
  input logic [CNT_W-1:0] cnt_q,
  input logic             armed_q,
  input logic             ent_mask,
  input logic             ent_per,
  input logic             req_valid
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  // R3: a running count above one falls by one per clock
  assert_count_down_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (armed_q && cnt_q > ONE && !load_en) |=> (cnt_q == $past(cnt_q) - ONE));

  // R4: a request only follows an expiry of an armed count
  assert_req_after_expiry_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (armed_q && !(cnt_q == ONE && !load_en)) |=> !req_valid);

  // R5: masked expiry raises nothing
  assert_masked_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (armed_q && cnt_q == ONE && !load_en && ent_mask) |=> !req_valid);

  // R6: periodic expiry reloads the starting count
  assert_periodic_reload_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (armed_q && cnt_q == ONE && !load_en && ent_per) |=> (cnt_q == $past(start_q) && armed_q));

  // R7: one-shot expiry stops at zero
  assert_oneshot_stop_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (armed_q && cnt_q == ONE && !load_en && !ent_per) |=> (cnt_q == '0 && !armed_q));

  // R8: an idle timer raises no request
  assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!armed_q) |=> !req_valid);
endmodule

bind irq_count_timer irq_count_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .load_en   (load_en),
  .start_q   (start_q),
  .cnt_q     (cnt_q),
  .armed_q   (armed_q),
  .ent_mask  (ent_mask),
  .ent_per   (ent_per),
  .req_valid (req_valid)
);

// File: tb/irq_count_timer_bench.sv
`timescale 1ns/1ps
module irq_count_timer_bench;
  logic        clk;
  logic        rst_n;
  logic        wr_en;
  logic [1:0]  addr;
  logic [31:0] wdata;
  logic [31:0] rdata;
  logic        req_valid;
  logic [7:0]  req_vector;
  logic [2:0]  req_mode;
  logic        req_level;

  int checks;
  int failures;
  bit done;

  irq_count_timer u_irq_count_timer (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .req_valid(req_valid), .req_vector(req_vector),
    .req_mode(req_mode), .req_level(req_level)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic do_write(input logic [1:0] a, input logic [31:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic do_read(input logic [1:0] a, output logic [31:0] d);
    addr = a;
    #1;
    d = rdata;
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    logic [31:0] rd;
    logic [31:0] ent;
    checks = 0; failures = 0; done = 0;
    wr_en = 0; addr = 0; wdata = 0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    for (int a = 0; a < 4; a++) begin
      do_read(2'(a), rd);
      chk("R1 reset read", rd, 32'h0);
    end
    chk("R1 reset req", {31'h0, req_valid}, 32'h0);

    // R2 entry write mask
    do_write(2'd0, 32'hFFFF_FFFF);
    do_read(2'd0, rd);
    chk("R2 all-ones readback", rd, 32'h0003_A7FF);
    do_write(2'd0, 32'h0000_5800);
    do_read(2'd0, rd);
    chk("R2 status/remote/bit11 read zero", rd, 32'h0);

    // Sweep of counts and control bits: R3 R4 R5 R6 R7
    for (int n = 1; n <= 5; n++) begin
      for (int cfg = 0; cfg < 8; cfg++) begin
        bit mk, pr, tg;
        logic [7:0] vec;
        logic [2:0] md;
        mk = cfg[0]; pr = cfg[1]; tg = cfg[2];
        vec = 8'((n * 37 + cfg * 11) % 256);
        md  = 3'((n + cfg) % 8);
        ent = {14'h0, pr, mk, tg, 4'h0, md, vec};
        do_write(2'd0, ent);
        do_write(2'd1, 32'(n));
        do_read(2'd2, rd);
        chk("R3 load value", rd, 32'(n));
        for (int i = 1; i <= 3 * n; i++) begin
          int  ecnt;
          bit  ereq;
          step();
          if (pr) begin
            ecnt = (i % n == 0) ? n : n - (i % n);
            ereq = (i % n == 0) && !mk;
          end else begin
            ecnt = (i < n) ? n - i : 0;
            ereq = (i == n) && !mk;
          end
          do_read(2'd2, rd);
          if (pr) chk("R6 live count", rd, 32'(ecnt));
          else if (i < n) chk("R3 live count", rd, 32'(ecnt));
          else chk("R7 live count", rd, 32'(ecnt));
          if (mk) chk("R5 masked request", {31'h0, req_valid}, {31'h0, ereq});
          else if (pr) chk("R6 request", {31'h0, req_valid}, {31'h0, ereq});
          else chk("R4 R7 request", {31'h0, req_valid}, {31'h0, ereq});
          if (ereq && req_valid) begin
            chk("R4 vector", {24'h0, req_vector}, {24'h0, vec});
            chk("R4 mode", {29'h0, req_mode}, {29'h0, md});
            chk("R4 level", {31'h0, req_level}, {31'h0, tg});
          end
        end
        do_write(2'd1, 32'h0);
      end
    end

    // R8 disarm by writing zero
    do_write(2'd0, 32'h0002_0042);
    do_write(2'd1, 32'd5);
    step(); step();
    do_write(2'd1, 32'd0);
    do_read(2'd2, rd);
    chk("R8 disarmed count", rd, 32'h0);
    for (int i = 0; i < 12; i++) begin
      step();
      chk("R8 no request", {31'h0, req_valid}, 32'h0);
    end
    do_read(2'd2, rd);
    chk("R8 count stays zero", rd, 32'h0);

    // R9 R10 ignored addresses and starting-count readback
    do_write(2'd0, 32'h0001_0011);
    do_write(2'd1, 32'd9);
    do_write(2'd2, 32'h0000_1234);
    do_read(2'd2, rd);
    chk("R9 live write ignored", rd, 32'd8);
    do_write(2'd3, 32'hFFFF_FFFF);
    do_read(2'd3, rd);
    chk("R9 addr3 reads zero", rd, 32'h0);
    do_read(2'd0, rd);
    chk("R9 entry unchanged", rd, 32'h0001_0011);
    do_read(2'd1, rd);
    chk("R10 start readback", rd, 32'd9);
    do_read(2'd2, rd);
    chk("R9 count kept running", rd, 32'd7);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule